// File: doc/BRIEF.md
# Input Capture Duty Cycle Timer

This block is a 16-bit timer with input capture that measures a digital input signal over and over. The raw input pin goes through a two-flop synchronizer and an edge detector. Each qualified edge copies the running counter into a capture register. Only the edge selected by the polarity setting reloads the counter, provided reload-on-capture is enabled and gating is on. The opposite edge only captures.

With the falling edge as the polarity edge, the values alternate. The rising edge captures the low time of the input, and the next falling edge captures the full period and restarts the count. The unit stays armed, so every later cycle is measured in the same way without any re-arming. A phase flag tells which of the two values is in the capture register. A one-cycle interrupt pulse marks every capture. In single-shot mode the unit waits for the first polarity edge after it is started, so a cycle already in progress is never measured.

Top module: `duty_capture_timer`

## Requirements
- R1: After reset the capture register, the phase flag, the interrupt and the overflow flag are all 0, and the counter holds 0000h.
- R2: A pin change that lands between clock edges updates `capture_o`, `phase_o` and `irq_o` on the third rising clock edge after the change. Nothing changes on the two edges before it.
- R3: With `pol_i`=1, `gate_en_i`=1 and `reload_en_i`=1, a falling edge captures and loads the counter from `reload_val_i`, and a rising edge only captures. The rising edge captures reload+L-1 and the next falling edge captures reload+P-1, where L is the low time and P is the period in clocks at divide-by-1. The cycle repeats without being re-armed.
- R4: With `pol_i`=0 the two edges swap roles: the rising edge captures and reloads, and the falling edge only captures.
- R5: With `oneshot_i`=1, starting the unit leaves the counter held and ignores all non-polarity edges (no capture, no interrupt). The first polarity edge captures, reloads and arms the unit.
- R6: With `gate_en_i`=0 and reload enabled, both edges reload, so the second capture gives the high (or low) time rather than the period.
- R7: With `reload_en_i`=0 no edge reloads the counter. It runs freely, and the difference between two successive captures is the time between the edges.
- R8: `phase_o` is 1 after a capture on the polarity edge (a period) and 0 after a capture on the other edge (a low time at `pol_i`=1).
- R9: `irq_o` is a single-cycle pulse on each capture when `irq_en_i`=1. It stays 0 when `irq_en_i`=0, while captures still take place.
- R10: `presc_sel_i`=s advances the counter once every 2^s clocks (code 0 counts every clock). A reload restarts the prescaler phase, so the first increment comes 2^s clocks after the reload.
- R11: When the counter wraps from FFFFh to 0000h, `ovf_o` is set and stays set until the next polarity-edge capture clears it. On a cycle where both happen, the clear wins.
- R12: While `run_i`=0 the counter holds its value, edges are ignored and the single-shot arming is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw input signal being measured |
| presc_sel_i | input | 3 | Prescaler select; count every 2^value clocks |
| pol_i | input | 1 | 1: falling edge is the reload/period edge; 0: rising edge |
| oneshot_i | input | 1 | Wait for the first polarity edge before counting |
| gate_en_i | input | 1 | Suppress reload on the non-polarity edge |
| reload_en_i | input | 1 | Load the counter from the reload value on a capture |
| run_i | input | 1 | Run enable |
| irq_en_i | input | 1 | Interrupt enable |
| reload_val_i | input | 16 | Reload value |
| capture_o | output | 16 | Last captured counter value |
| phase_o | output | 1 | 1: last capture was a period; 0: a low time |
| irq_o | output | 1 | One-cycle capture interrupt |
| ovf_o | output | 1 | Sticky counter wrap flag |

## Verification
Every capture result (`capture_o`, `phase_o`, `irq_o`) is due on the third rising edge after a pin change. The bench drives the pin on falling clock edges and checks the interrupt both on the second and on the third following edge. A behavioural model in the bench replays the synchronizer delay with a queue of pin samples. It is compared with all four outputs at every falling clock edge, so a result one cycle early or late shows up at once. Directed checks compare the captured low times, periods, prescaled counts and wrap values with figures worked out from the requirement formulas.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic {
    PH_LOW    = 1'b0,
    PH_PERIOD = 1'b1
  } phase_e;
  localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/dct_edge_sync.sv
module dct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~last_q;
  assign fall_o = ~level & last_q;

  p_single_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_single_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dct_prescale.sv
module dct_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << sel_i);
  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (!run_i || clr_i)  div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  p_div1_every_clk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel_i == '0) |-> tick_o);
  p_restart_no_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && run_i && sel_i != '0) |=> !tick_o);
endmodule

// File: rtl/dct_capture_core.sv
module dct_capture_core
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             oneshot_i,
  input  logic             gate_en_i,
  input  logic             reload_en_i,
  input  logic             pol_i,
  input  logic             irq_en_i,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             load_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             phase_o,
  output logic             irq_o,
  output logic             ovf_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  phase_e           phase_q;
  logic             irq_q, ovf_q;
  logic             pol_edge, np_edge, active, start, cap_evt, do_load, wrap;

  assign pol_edge = pol_i ? fall_i : rise_i;
  assign np_edge  = pol_i ? rise_i : fall_i;
  assign active   = run_i && (armed_q || !oneshot_i);
  assign start    = run_i && oneshot_i && !armed_q && pol_edge;
  assign cap_evt  = (active && (pol_edge || np_edge)) || start;
  // gating masks the reload on the non-polarity edge
  assign do_load  = cap_evt && reload_en_i && (pol_edge || !gate_en_i);
  assign wrap     = active && tick_i && !do_load && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      cap_q   <= '0;
      phase_q <= PH_LOW;
      irq_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (!run_i)     armed_q <= 1'b0;
      else if (start) armed_q <= 1'b1;

      if (do_load)                cnt_q <= reload_val_i;
      else if (active && tick_i)  cnt_q <= cnt_q + 1'b1;

      if (cap_evt) begin
        cap_q   <= cnt_q;
        phase_q <= pol_edge ? PH_PERIOD : PH_LOW;
      end
      irq_q <= cap_evt && irq_en_i;

      if (cap_evt && pol_edge) ovf_q <= 1'b0;
      else if (wrap)           ovf_q <= 1'b1;
    end
  end

  assign load_o    = do_load;
  assign capture_o = cap_q;
  assign phase_o   = phase_q;
  assign irq_o     = irq_q;
  assign ovf_o     = ovf_q;

  p_reload_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_load |=> (cnt_q == $past(reload_val_i)));
  p_gate_no_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_i && np_edge && active && tick_i && cnt_q != {CNT_W{1'b1}}) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_unarmed_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && oneshot_i && !armed_q && np_edge) |=> ($stable(cap_q) && !irq_q));
  p_hold_stopped_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i) |=> $stable(cnt_q));
  p_ovf_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !(cap_evt && pol_edge)) |=> ovf_q);
  p_ovf_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && pol_edge) |=> !ovf_q);
endmodule

// File: rtl/duty_capture_timer.sv
module duty_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             pol_i,
  input  logic             oneshot_i,
  input  logic             gate_en_i,
  input  logic             reload_en_i,
  input  logic             run_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] capture_o,
  output logic             phase_o,
  output logic             irq_o,
  output logic             ovf_o
);
  logic rise, fall, tick, load;

  dct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  dct_prescale #(.SEL_W(SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .clr_i  (load),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  dct_capture_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .oneshot_i    (oneshot_i),
    .gate_en_i    (gate_en_i),
    .reload_en_i  (reload_en_i),
    .pol_i        (pol_i),
    .irq_en_i     (irq_en_i),
    .tick_i       (tick),
    .rise_i       (rise),
    .fall_i       (fall),
    .reload_val_i (reload_val_i),
    .load_o       (load),
    .capture_o    (capture_o),
    .phase_o      (phase_o),
    .irq_o        (irq_o),
    .ovf_o        (ovf_o)
  );

  p_irq_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));
  p_irq_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rise && !fall) |=> !irq_o);
endmodule

// File: tb/duty_capture_timer_tb.sv
module duty_capture_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic        pol = 1'b1, oneshot = 1'b1, gate = 1'b1, rel_en = 1'b1;
  logic        run = 1'b0, irq_en = 1'b1;
  logic [15:0] rv = 16'd1;
  logic [15:0] cap;
  logic        phase, irq, ovf;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  duty_capture_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .presc_sel_i(sel), .pol_i(pol),
    .oneshot_i(oneshot), .gate_en_i(gate), .reload_en_i(rel_en), .run_i(run),
    .irq_en_i(irq_en), .reload_val_i(rv), .capture_o(cap), .phase_o(phase),
    .irq_o(irq), .ovf_o(ovf)
  );

  // behavioural reference model
  bit q[$] = '{1'b0, 1'b0, 1'b0};
  int m_cnt = 0, m_cap = 0, m_div = 0;
  bit m_ph = 0, m_irq = 0, m_ovf = 0, m_arm = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit lvl, lst, r, f, pe, ne, act, st, ce, ld, tk;
      int per;
      lvl = q[1]; lst = q[2];
      r = lvl && !lst; f = !lvl && lst;
      pe = pol ? f : r; ne = pol ? r : f;
      act = run && (m_arm || !oneshot);
      st  = run && oneshot && !m_arm && pe;
      ce  = (act && (pe || ne)) || st;
      ld  = ce && rel_en && (pe || !gate);
      per = 1 << sel;
      tk  = run && ((m_div % per) == per - 1);
      m_irq = ce && irq_en;
      if (ce) begin m_cap = m_cnt; m_ph = pe; end
      if (ce && pe) m_ovf = 0;
      else if (act && tk && !ld && m_cnt == 65535) m_ovf = 1;
      if (ld) m_cnt = int'(rv);
      else if (act && tk) m_cnt = (m_cnt + 1) % 65536;
      m_div = (!run || ld) ? 0 : (m_div + 1) % 128;
      if (!run) m_arm = 0; else if (st) m_arm = 1;
      q.push_front(pin);
      void'(q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cap !== 16'(m_cap) || phase !== m_ph || irq !== m_irq || ovf !== m_ovf) begin
        errors++;
        $display("FAIL %s model: cap=%0d ph=%0b irq=%0b ovf=%0b expected cap=%0d ph=%0b irq=%0b ovf=%0b",
                 cur_req, cap, phase, irq, ovf, m_cap, m_ph, m_irq, m_ovf);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive pin at a falling edge, check capture timing, then hold
  task automatic edge_chk(bit v, int hold, string req, bit chk_v, int exp_v, bit exp_ph, bit exp_irq);
    cur_req = req;
    pin = v;
    @(negedge clk);
    @(negedge clk);
    chk("R2 irq early", int'(irq), 0);
    @(negedge clk);
    chk({req, " irq"}, int'(irq), int'(exp_irq));
    chk({req, " phase R8"}, int'(phase), int'(exp_ph));
    if (chk_v) chk({req, " capture"}, int'(cap), exp_v);
    repeat (hold - 3) @(negedge clk);
  endtask

  initial begin
    int c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 capture", int'(cap), 0);
    chk("R1 phase", int'(phase), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ovf", int'(ovf), 0);

    // single-shot duty measurement, falling edge polarity
    run = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R5";
    pin = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 ignored capture", int'(cap), 0);
    chk("R5 ignored irq", int'(irq), 0);
    edge_chk(1'b0, 20, "R5 start", 1, 0, 1, 1);
    edge_chk(1'b1, 30, "R3 low", 1, 20, 0, 1);
    edge_chk(1'b0, 10, "R3 period", 1, 50, 1, 1);
    edge_chk(1'b1, 15, "R3 low2", 1, 10, 0, 1);
    edge_chk(1'b0, 8, "R3 period2", 1, 25, 1, 1);

    // stopped: edges ignored
    cur_req = "R12";
    run = 1'b0;
    pin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 irq", int'(irq), 0);
    pin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12 capture", int'(cap), 25);
    chk("R12 irq", int'(irq), 0);

    // rising-edge polarity, continuous
    pol = 1'b0; oneshot = 1'b0; rv = 16'd0; run = 1'b1;
    repeat (3) @(negedge clk);
    edge_chk(1'b1, 12, "R4 start", 0, 0, 1, 1);
    edge_chk(1'b0, 8, "R4 high", 1, 11, 0, 1);
    edge_chk(1'b1, 10, "R4 period", 1, 19, 1, 1);

    // both edges reload
    pol = 1'b1; gate = 1'b0; rv = 16'd1;
    edge_chk(1'b0, 7, "R6 start", 0, 0, 1, 1);
    edge_chk(1'b1, 9, "R6 low", 1, 7, 0, 1);
    edge_chk(1'b0, 10, "R6 high", 1, 9, 1, 1);

    // free running
    gate = 1'b1; rel_en = 1'b0;
    edge_chk(1'b1, 5, "R7 rise", 0, 0, 0, 1);
    edge_chk(1'b0, 6, "R7 fall", 0, 0, 1, 1);
    c1 = int'(cap);
    edge_chk(1'b1, 6, "R7", 1, c1 + 6, 0, 1);

    // prescaler divide by 4
    rel_en = 1'b1; rv = 16'd0; sel = 3'd2;
    edge_chk(1'b0, 40, "R10 start", 0, 0, 1, 1);
    edge_chk(1'b1, 20, "R10 low", 1, 9, 0, 1);
    edge_chk(1'b0, 10, "R10 period", 1, 14, 1, 1);
    sel = 3'd0;

    // wrap and overflow flag
    edge_chk(1'b1, 6, "R11 pre", 0, 0, 0, 1);
    rv = 16'hFFF0;
    edge_chk(1'b0, 40, "R11 start", 0, 0, 1, 1);
    rv = 16'd1;
    edge_chk(1'b1, 10, "R11 low", 1, 23, 0, 1);
    chk("R11 ovf set", int'(ovf), 1);
    edge_chk(1'b0, 12, "R11 period", 1, 33, 1, 1);
    chk("R11 ovf cleared", int'(ovf), 0);

    // interrupt disabled
    irq_en = 1'b0;
    edge_chk(1'b1, 9, "R9 masked", 1, 12, 0, 0);
    edge_chk(1'b0, 6, "R9 masked", 1, 21, 1, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule